// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous SRAM that keeps the data bus busy on every clock cycle, whatever the mix of reads and writes. All control, address and write data are captured on the rising clock edge. The output enable is the only asynchronous input.

A read returns its word on the bus in the cycle after the next edge. A write takes its data from the bus two edges after its address. Read data and write data therefore use the same bus slot, so a read and a write may follow each other on every cycle without an idle cycle.

The 64-bit word is held as two 32-bit halves, and each half has its own write enable. The depth of the array is a parameter. A write that is still waiting for its data is forwarded to a read of the same address. The data bus is presented as a data-in vector, a data-out vector and a drive-enable flag, so that the tristate pad sits outside the block.

Top module: `noturn_sram`

## Requirements
- R1: `rst` is synchronous and active high. A reset edge discards every command in flight, including a write whose data has not yet been taken. In the cycle after a reset edge `dq_oe` is low. The array keeps its contents.
- R2: A read registered at edge k, with `oe_n` low, presents the addressed word on `dq_out` with `dq_oe` high between edge k+1 and edge k+2.
- R3: A write registered at edge k stores the value that `dq_in` holds at edge k+2. `dq_in` is ignored at every other edge, and `dq_oe` is low in that bus slot.
- R4: `half_we_n` is active low. Bit 0 low lets a write update bits 31:0, and bit 1 low lets it update bits 63:32. A half whose bit is high keeps its old value.
- R5: The chip is selected only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. A cycle in which any of the three disagrees starts nothing. It neither writes the array nor drives the bus two edges later.
- R6: A selected read while `oe_n` is high is a dummy read. The pipeline advances, but the bus is not driven, and following reads are unaffected.
- R7: `oe_n` high forces `dq_oe` low immediately, at any time within a cycle. Lowering it again within the cycle re-exposes the pending read word.
- R8: Reads and writes to any addresses may alternate on every edge with no idle cycle. Every read returns the data of all writes registered before it.
- R9: A read registered one edge after a write to the same address returns the new data in the written halves and the old data in the other half.
- R10: A selected write with both bits of `half_we_n` high leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| sel_a_n | input | 1 | Chip select term, active low |
| sel_b | input | 1 | Chip select term, active high |
| sel_c_n | input | 1 | Chip select term, active low |
| wr_n | input | 1 | 0 = write, 1 = read, sampled at the edge |
| half_we_n | input | HALVES (2) | Per-half write enables, active low; bit 0 selects the low half |
| addr | input | ADDR_W (4) | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | HALF_W*HALVES (64) | Write data from the bus, taken two edges after the address |
| dq_out | output | HALF_W*HALVES (64) | Read data toward the bus pad |
| dq_oe | output | 1 | High when the pad must drive `dq_out`; low means high impedance |

## Verification
The bench first fills the array with full-word writes and reads it back in order, which separates a wrong read latency from a wrong write-data slot. Single-half writes, writes with both halves disabled, and each of the three select terms negated in turn show whether the masking and the decoding of the selects are right. A write followed at once by a read of the same address, compared with the same pair with a one-cycle gap, tells a working forward path from a stale array read. Strict read/write alternation and a long random mix of reads, writes, deselects and output-enable changes then confirm that no bus slot is lost. A reset between a write and its data slot shows that pending work is discarded while the array survives.

// File: rtl/noturn_sram_pkg.sv
`timescale 1ns/1ps
package noturn_sram_pkg;

   // Operation carried by each pipeline stage; IDLE is the bubble.
   typedef enum logic [1:0] {
      NTS_IDLE  = 2'd0,
      NTS_READ  = 2'd1,
      NTS_WRITE = 2'd2
   } nts_op_e;

   // Three-term chip select decode.
   function automatic logic nts_chip_on(input logic a_n, input logic b, input logic c_n);
      return !a_n && b && !c_n;
   endfunction

endpackage

// File: rtl/nts_cmd_pipe.sv
`timescale 1ns/1ps
module nts_cmd_pipe
   import noturn_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int HALVES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              wr_n,
   input  logic [HALVES-1:0] half_we_n,
   input  logic [ADDR_W-1:0] addr,
   output nts_op_e           s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output nts_op_e           s2_op,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [HALVES-1:0] s2_en
);

   localparam int STAGES = 2;

   nts_op_e           op_in   [STAGES];
   logic [ADDR_W-1:0] addr_in [STAGES];
   logic [HALVES-1:0] en_in   [STAGES];
   nts_op_e           op_q    [STAGES];
   logic [ADDR_W-1:0] addr_q  [STAGES];
   logic [HALVES-1:0] en_q    [STAGES];

   nts_op_e new_op;

   always_comb begin
      if (!nts_chip_on(sel_a_n, sel_b, sel_c_n)) new_op = NTS_IDLE;
      else if (wr_n)                             new_op = NTS_READ;
      else                                       new_op = NTS_WRITE;
   end

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_head
            assign op_in[g]   = new_op;
            assign addr_in[g] = addr;
            assign en_in[g]   = ~half_we_n;
         end else begin : g_tail
            assign op_in[g]   = op_q[g-1];
            assign addr_in[g] = addr_q[g-1];
            assign en_in[g]   = en_q[g-1];
         end

         always_ff @(posedge clk) begin
            if (rst) op_q[g] <= NTS_IDLE;
            else     op_q[g] <= op_in[g];
            addr_q[g] <= addr_in[g];
            en_q[g]   <= en_in[g];
         end
      end
   endgenerate

   assign s1_op   = op_q[0];
   assign s1_addr = addr_q[0];
   assign s2_op   = op_q[1];
   assign s2_addr = addr_q[1];
   assign s2_en   = en_q[1];

endmodule

// File: rtl/nts_array.sv
`timescale 1ns/1ps
module nts_array #(
   parameter int ADDR_W = 4,
   parameter int HALF_W = 32,
   parameter int HALVES = 2
) (
   input  logic                     clk,
   input  logic [HALVES-1:0]        we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [HALF_W*HALVES-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [HALF_W*HALVES-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   genvar h;
   generate
      for (h = 0; h < HALVES; h++) begin : g_bank
         logic [HALF_W-1:0] bank [DEPTH];

         always_ff @(posedge clk) begin
            if (we[h]) bank[waddr] <= wdata[h*HALF_W +: HALF_W];
         end

         assign rdata[h*HALF_W +: HALF_W] = bank[raddr];
      end
   endgenerate

endmodule

// File: rtl/nts_read_port.sv
`timescale 1ns/1ps
module nts_read_port
   import noturn_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int HALF_W = 32,
   parameter int HALVES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  nts_op_e                  s1_op,
   input  logic [ADDR_W-1:0]        s1_addr,
   input  nts_op_e                  s2_op,
   input  logic [ADDR_W-1:0]        s2_addr,
   input  logic [HALVES-1:0]        s2_en,
   input  logic [HALF_W*HALVES-1:0] bus_wdata,
   input  logic [HALF_W*HALVES-1:0] arr_rdata,
   output logic [HALF_W*HALVES-1:0] q,
   output logic                     q_vld
);

   localparam int DW = HALF_W * HALVES;

   logic            same_word;
   logic [DW-1:0]   q_nxt;

   // The only write not yet in the array is the one committing at this edge.
   assign same_word = (s2_op == NTS_WRITE) && (s2_addr == s1_addr);

   genvar h;
   generate
      for (h = 0; h < HALVES; h++) begin : g_fwd
         assign q_nxt[h*HALF_W +: HALF_W] = (same_word && s2_en[h])
                                          ? bus_wdata[h*HALF_W +: HALF_W]
                                          : arr_rdata[h*HALF_W +: HALF_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q_vld <= 1'b0;
      else     q_vld <= (s1_op == NTS_READ);
      if (s1_op == NTS_READ) q <= q_nxt;
   end

endmodule

// File: rtl/noturn_sram.sv
`timescale 1ns/1ps
module noturn_sram
   import noturn_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int HALF_W = 32,
   parameter int HALVES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     sel_a_n,
   input  logic                     sel_b,
   input  logic                     sel_c_n,
   input  logic                     wr_n,
   input  logic [HALVES-1:0]        half_we_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     oe_n,
   input  logic [HALF_W*HALVES-1:0] dq_in,
   output logic [HALF_W*HALVES-1:0] dq_out,
   output logic                     dq_oe
);

   localparam int DW = HALF_W * HALVES;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
         $error("noturn_sram: ADDR_W must be within 1..12");
      end
      if (HALF_W < 1) begin : g_bad_hw
         $error("noturn_sram: HALF_W must be positive");
      end
      if (HALVES < 1 || HALVES > 8) begin : g_bad_hv
         $error("noturn_sram: HALVES must be within 1..8");
      end
   endgenerate

   nts_op_e           s1_op, s2_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [HALVES-1:0] s2_en;
   logic [HALVES-1:0] commit_we;
   logic [DW-1:0]     arr_rdata;
   logic [DW-1:0]     q;
   logic              q_vld;

   nts_cmd_pipe #(.ADDR_W(ADDR_W), .HALVES(HALVES)) u_cmd (
      .clk       (clk),
      .rst       (rst),
      .sel_a_n   (sel_a_n),
      .sel_b     (sel_b),
      .sel_c_n   (sel_c_n),
      .wr_n      (wr_n),
      .half_we_n (half_we_n),
      .addr      (addr),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .s2_op     (s2_op),
      .s2_addr   (s2_addr),
      .s2_en     (s2_en)
   );

   // Late-late commit: data comes straight from the bus two edges after the address.
   assign commit_we = (s2_op == NTS_WRITE && !rst) ? s2_en : '0;

   nts_array #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .HALVES(HALVES)) u_arr (
      .clk   (clk),
      .we    (commit_we),
      .waddr (s2_addr),
      .wdata (dq_in),
      .raddr (s1_addr),
      .rdata (arr_rdata)
   );

   nts_read_port #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .HALVES(HALVES)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .s2_op     (s2_op),
      .s2_addr   (s2_addr),
      .s2_en     (s2_en),
      .bus_wdata (dq_in),
      .arr_rdata (arr_rdata),
      .q         (q),
      .q_vld     (q_vld)
   );

   assign dq_out = q;
   assign dq_oe  = q_vld && !oe_n;

endmodule

// File: rtl/noturn_sram_chk.sv
`timescale 1ns/1ps
module noturn_sram_chk
   import noturn_sram_pkg::*;
(
   input logic clk,
   input logic rst,
   input logic sel_a_n,
   input logic sel_b,
   input logic sel_c_n,
   input logic wr_n,
   input logic oe_n,
   input logic dq_oe
);

   logic cs;
   assign cs = nts_chip_on(sel_a_n, sel_b, sel_c_n);

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !dq_oe);

   // R2
   read_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (cs && wr_n) |=> ##1 (oe_n || dq_oe));

   // R3
   write_slot_chk: assert property (@(posedge clk) disable iff (rst)
      (cs && !wr_n) |=> ##1 !dq_oe);

   // R5
   desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !cs |=> ##1 !dq_oe);

   // R7
   oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
      oe_n |-> !dq_oe);

   // R7
   always_comb begin
      if (oe_n === 1'b1) oe_gate_now_chk: assert (dq_oe !== 1'b1);
   end

endmodule

bind noturn_sram noturn_sram_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .sel_a_n (sel_a_n),
   .sel_b   (sel_b),
   .sel_c_n (sel_c_n),
   .wr_n    (wr_n),
   .oe_n    (oe_n),
   .dq_oe   (dq_oe)
);

// File: tb/sim_noturn_sram.sv
`timescale 1ns/1ps
module sim_noturn_sram;

   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sa_n = 1'b1, sb = 1'b0, sc_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [1:0]  hen_n = 2'b11;
   logic [AW-1:0] addr = '0;
   logic        oe_n = 1'b1;
   logic [63:0] dq_in = '0;
   logic [63:0] dq_out;
   logic        dq_oe;

   int nchk = 0;
   int nfail = 0;

   // reference model state
   logic [63:0] rmem [DEPTH];
   bit          s1_v = 0, s1_wr = 0, s2_v = 0, s2_wr = 0;
   logic [1:0]  s1_en, s2_en;
   int          s1_a, s2_a;
   logic [63:0] s1_d, s2_d;
   string       s1_tag = "", s2_tag = "";
   bit          exp_v = 0;
   logic [63:0] exp_d;
   string       exp_tag = "";
   logic [2:0]  dpat = 3'b110;  // {sa_n, sb, sc_n} used on deselect steps

   noturn_sram #(.ADDR_W(AW), .HALF_W(32), .HALVES(2)) u0 (
      .clk(clk), .rst(rst), .sel_a_n(sa_n), .sel_b(sb), .sel_c_n(sc_n),
      .wr_n(wr_n), .half_we_n(hen_n), .addr(addr), .oe_n(oe_n),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #2 clk = ~clk;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      #400000;
      nfail++;
      $display("FAIL watchdog: run did not finish (actual running, expected done)");
      summary();
      $finish;
   end

   task automatic exp_bit(input logic got, input logic want, input string tag);
      nchk++;
      if (got !== want) begin
         nfail++;
         $display("FAIL %s dq_oe actual %b expected %b at %0t", tag, got, want, $time);
      end
   endtask

   task automatic exp_word(input logic [63:0] got, input logic [63:0] want, input string tag);
      nchk++;
      if (got !== want) begin
         nfail++;
         $display("FAIL %s dq_out actual %h expected %h at %0t", tag, got, want, $time);
      end
   endtask

   task automatic check_out();
      bit drv;
      drv = exp_v && (oe_n == 1'b0);
      exp_bit(dq_oe, drv, exp_tag);
      if (drv) exp_word(dq_out, exp_d, exp_tag);
   endtask

   // One clock: check current output slot, drive the next command, update the model.
   task automatic step(input bit sel, input bit wr, input logic [1:0] en,
                       input int a, input bit oe_lo, input string tag);
      logic [63:0] nd;
      @(negedge clk);
      check_out();
      nd = {$urandom(), $urandom()};
      {sa_n, sb, sc_n} = sel ? 3'b010 : dpat;
      wr_n  = ~wr;
      hen_n = ~en;
      addr  = a[AW-1:0];
      oe_n  = ~oe_lo;
      dq_in = (s2_v && s2_wr) ? s2_d : {$urandom(), $urandom()};
      @(posedge clk);
      if (rst) begin
         s1_v = 0; s2_v = 0; exp_v = 0;
      end else begin
         if (s2_v && s2_wr) begin
            if (s2_en[0]) rmem[s2_a][31:0]  = s2_d[31:0];
            if (s2_en[1]) rmem[s2_a][63:32] = s2_d[63:32];
         end
         exp_v   = s1_v && !s1_wr;
         exp_d   = rmem[s1_a];
         exp_tag = s1_tag;
         s2_v = s1_v; s2_wr = s1_wr; s2_en = s1_en; s2_a = s1_a; s2_d = s1_d; s2_tag = s1_tag;
         s1_v = sel; s1_wr = wr; s1_en = en; s1_a = a % DEPTH; s1_d = nd; s1_tag = tag;
      end
   endtask

   task automatic idle(input int n, input bit oe_lo);
      for (int i = 0; i < n; i++) step(0, 0, 2'b00, 0, oe_lo, "R5");
   endtask

   task automatic t_fill();
      for (int a = 0; a < DEPTH; a++) step(1, 1, 2'b11, a, 1, "R3");
      idle(2, 1);
      for (int a = 0; a < DEPTH; a++) step(1, 0, 2'b00, a, 1, "R2");
      idle(2, 1);
   endtask

   task automatic t_halves();
      step(1, 1, 2'b01, 3, 1, "R4");
      step(1, 1, 2'b10, 5, 1, "R4");
      idle(2, 1);
      step(1, 0, 2'b00, 3, 1, "R4");
      step(1, 0, 2'b00, 5, 1, "R4");
      idle(2, 1);
   endtask

   task automatic t_desel();
      logic [2:0] pats [3] = '{3'b110, 3'b000, 3'b011};
      for (int p = 0; p < 3; p++) begin
         dpat = pats[p];
         step(0, 1, 2'b11, 7, 1, "R5");
         step(0, 0, 2'b00, 7, 1, "R5");
         idle(2, 1);
         step(1, 0, 2'b00, 7, 1, "R5");
         idle(2, 1);
      end
      dpat = 3'b110;
   endtask

   task automatic t_dummy();
      step(1, 0, 2'b00, 2, 0, "R6");
      step(1, 0, 2'b00, 4, 0, "R6");
      step(0, 0, 2'b00, 0, 1, "R6");
      step(0, 0, 2'b00, 0, 1, "R6");
      idle(1, 1);
   endtask

   task automatic t_oe();
      step(1, 0, 2'b00, 9, 1, "R7");
      step(0, 0, 2'b00, 0, 0, "R7");
      // now inside the read's bus slot with oe_n high
      #0.4;
      exp_bit(dq_oe, 1'b0, "R7");
      oe_n = 1'b0;
      #0.4;
      exp_bit(dq_oe, 1'b1, "R7");
      exp_word(dq_out, exp_d, "R7");
      oe_n = 1'b1;
      #0.4;
      exp_bit(dq_oe, 1'b0, "R7");
      idle(2, 1);
   endtask

   task automatic t_forward();
      step(1, 1, 2'b01, 6, 1, "R9");
      step(1, 0, 2'b00, 6, 1, "R9");
      step(1, 1, 2'b10, 6, 1, "R9");
      step(1, 0, 2'b00, 6, 1, "R9");
      step(1, 1, 2'b11, 6, 1, "R9");
      step(0, 0, 2'b00, 0, 1, "R9");
      step(1, 0, 2'b00, 6, 1, "R9");
      idle(2, 1);
   endtask

   task automatic t_abort();
      step(1, 1, 2'b00, 8, 1, "R10");
      idle(2, 1);
      step(1, 0, 2'b00, 8, 1, "R10");
      idle(2, 1);
   endtask

   task automatic t_reset();
      step(1, 1, 2'b11, 1, 1, "R1");
      step(1, 0, 2'b00, 1, 1, "R1");
      rst = 1'b1;
      step(0, 0, 2'b00, 0, 1, "R1");
      rst = 1'b0;
      step(0, 0, 2'b00, 0, 1, "R1");
      step(1, 0, 2'b00, 1, 1, "R1");
      idle(2, 1);
   endtask

   task automatic t_pingpong();
      for (int i = 0; i < 40; i++)
         step(1, (i % 2) == 0, 2'b11, $urandom_range(DEPTH-1), 1, "R8");
      for (int i = 0; i < 300; i++)
         step($urandom_range(9) < 8, $urandom_range(1), 2'($urandom_range(3)),
              $urandom_range(DEPTH-1), $urandom_range(9) != 0, "R8");
      idle(2, 1);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      exp_bit(dq_oe, 1'b0, "R1");
      t_fill();
      t_halves();
      t_desel();
      t_dummy();
      t_oe();
      t_forward();
      t_abort();
      t_reset();
      t_pingpong();
      summary();
      $finish;
   end

endmodule